// File: doc/BRIEF.md
# Three-Wire Bus Ownership Arbiter

This block decides who drives a shared bus: the local master or an external master. An external master pulls an active-low request line, which may be wire-ORed among several masters. The arbiter answers with an active-low grant. It waits until the local bus cycle in flight has finished, including both halves of an indivisible read-modify-write. Then it turns off the local address, data and control drivers. Ownership comes back when the external master releases.

Two release handshakes are supported. In three-wire mode the external master takes the bus by asserting an active-low acknowledge, and the grant is then removed. The local master stays off the bus until that acknowledge is negated. In two-wire mode the acknowledge input has no role, and the bus returns as soon as the request is negated. In either mode, if the request disappears before any acknowledge is seen, the grant is withdrawn and the local master simply carries on. Request and acknowledge are asynchronous, so both pass through a synchroniser chain before the state machine uses them.

Top module: `busarb_top`

## Requirements
- R1: While reset is asserted and on leaving it, `grant_no` is high (no grant) and `bus_off_o` is low (local drivers enabled).
- R2: Request and acknowledge pass through SYNC_STAGES (default 2) flops. `grant_no` goes low on exactly the (SYNC_STAGES+1)-th rising edge after `req_ni` falls, whether or not a local cycle is in progress.
- R3: `bus_off_o` rises only on an edge where `cyc_active_i` was low, and never while a granted local cycle or read-modify-write pair keeps `cyc_active_i` high. If `cyc_active_i` is already low, `bus_off_o` rises one edge after the grant.
- R4: If the synchronised request is negated with no acknowledge seen, `grant_no` returns high. `bus_off_o` is low on the same edge, whether the drivers had been turned off yet or not.
- R5: In three-wire mode (`two_wire_i`=0), a synchronised acknowledge while the bus is released drives `grant_no` high, and `bus_off_o` stays high.
- R6: In three-wire mode, after the acknowledge is negated with no request pending, `bus_off_o` falls SYNC_STAGES+1 edges after `ack_ni` rises.
- R7: In three-wire mode, if the request is still asserted when the acknowledge is negated, `grant_no` goes low again SYNC_STAGES+1 edges later. `bus_off_o` stays high throughout.
- R8: In two-wire mode (`two_wire_i`=1), `ack_ni` has no effect on `grant_no` or `bus_off_o`. Negating the request returns the bus (`grant_no` high, `bus_off_o` low) SYNC_STAGES+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| two_wire_i | input | 1 | 1 = two-wire release handshake, 0 = three-wire |
| req_ni | input | 1 | External bus request, active low, asynchronous |
| ack_ni | input | 1 | External grant acknowledge, active low, asynchronous |
| cyc_active_i | input | 1 | Local bus cycle (or RMW pair) in progress |
| grant_no | output | 1 | Bus grant, active low |
| bus_off_o | output | 1 | Place local bus drivers in high impedance |

## Verification
A corrupt arbiter state shows at the ports within one clock edge, as a mismatched pair of `grant_no` and `bus_off_o`. Two examples: drivers turned off while a local cycle is still marked active, or a grant reappearing with no request behind it. Synchroniser faults appear as grant or release edges that come one cycle early or late, so every handshake is checked on the exact edge. A release-path fault is visible the first time the acknowledge or request is negated. Either the bus stays off or it returns while the external master still holds it.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    ST_OWN      = 2'd0,  // local master owns the bus
    ST_GRANT    = 2'd1,  // grant out, local cycle may still run
    ST_RELEASED = 2'd2,  // grant out, drivers off
    ST_EXT      = 2'd3   // external master acknowledged, drivers off
  } arb_state_e;
endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
  import busarb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic two_wire_i,
  input  logic req_i,
  input  logic ack_i,
  input  logic cyc_active_i,
  output logic grant_no,
  output logic bus_off_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN: if (req_i) state_d = ST_GRANT;
      ST_GRANT: begin
        if (!req_i && (two_wire_i || !ack_i)) state_d = ST_OWN;
        else if (!cyc_active_i)               state_d = ST_RELEASED;
      end
      ST_RELEASED: begin
        if (!two_wire_i && ack_i) state_d = ST_EXT;
        else if (!req_i)          state_d = ST_OWN;
      end
      ST_EXT: begin
        if (two_wire_i) begin
          if (!req_i) state_d = ST_OWN;
        end else if (!ack_i) begin
          state_d = req_i ? ST_RELEASED : ST_OWN;  // regrant without resuming
        end
      end
      default: state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OWN;
      grant_no  <= 1'b1;
      bus_off_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      grant_no  <= !(state_d == ST_GRANT || state_d == ST_RELEASED);
      bus_off_o <= (state_d == ST_RELEASED || state_d == ST_EXT);
    end
  end
endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic two_wire_i,
  input  logic req_ni,
  input  logic ack_ni,
  input  logic cyc_active_i,
  output logic grant_no,
  output logic bus_off_o
);
  logic req_sn, ack_sn;
  logic req_s, ack_s;

  busarb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_ni), .q_o(req_sn)
  );
  busarb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_ni), .q_o(ack_sn)
  );

  assign req_s = ~req_sn;
  assign ack_s = ~ack_sn;

  busarb_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .two_wire_i  (two_wire_i),
    .req_i       (req_s),
    .ack_i       (ack_s),
    .cyc_active_i(cyc_active_i),
    .grant_no    (grant_no),
    .bus_off_o   (bus_off_o)
  );
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic two_wire_i,
  input logic cyc_active_i,
  input logic grant_no,
  input logic bus_off_o,
  input logic req_s,
  input logic ack_s
);
  p_grant_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_no) |-> $past(req_s));

  p_off_after_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_off_o) |-> !$past(cyc_active_i));

  p_withdraw_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(grant_no) && !bus_off_o) |-> !$past(req_s));

  p_return_ungranted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> grant_no);

  p_ack_drops_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!two_wire_i && !grant_no && bus_off_o && ack_s) |=> (grant_no && bus_off_o));

  p_return_needs_no_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_off_o) && !two_wire_i && !$past(two_wire_i)) |-> !$past(ack_s));

  p_regrant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!two_wire_i && grant_no && bus_off_o && !ack_s && req_s) |=> (!grant_no && bus_off_o));

  p_ack_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (two_wire_i && !grant_no && bus_off_o && req_s) |=> (!grant_no && bus_off_o));
endmodule

bind busarb_top busarb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .two_wire_i  (two_wire_i),
  .cyc_active_i(cyc_active_i),
  .grant_no    (grant_no),
  .bus_off_o   (bus_off_o),
  .req_s       (req_s),
  .ack_s       (ack_s)
);

// File: tb/tb_busarb_top.sv
module tb_busarb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic two_wire = 1'b0;
  logic req_n = 1'b1;
  logic ack_n = 1'b1;
  logic cyc = 1'b0;
  logic grant_n, bus_off;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  busarb_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .two_wire_i(two_wire), .req_ni(req_n),
    .ack_ni(ack_n), .cyc_active_i(cyc), .grant_no(grant_n), .bus_off_o(bus_off)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    check("R1 grant_no in reset", grant_n, 1'b1);
    check("R1 bus_off in reset", bus_off, 1'b0);
    rst_ni = 1'b1;
    tick(2);
    check("R1 grant_no after reset", grant_n, 1'b1);
    check("R1 bus_off after reset", bus_off, 1'b0);
  endtask

  task automatic t_three_wire_idle;
    req_n = 1'b0;
    tick(2);
    check("R2 grant not early", grant_n, 1'b1);
    tick(1);
    check("R2 grant on edge 3", grant_n, 1'b0);
    check("R3 drivers on at grant", bus_off, 1'b0);
    tick(1);
    check("R3 release one edge later", bus_off, 1'b1);
    ack_n = 1'b0;
    tick(2);
    check("R5 grant held before ack sync", grant_n, 1'b0);
    tick(1);
    check("R5 grant dropped on ack", grant_n, 1'b1);
    check("R5 drivers stay off", bus_off, 1'b1);
    req_n = 1'b1;
    tick(4);
    check("R6 off while ack held", bus_off, 1'b1);
    ack_n = 1'b1;
    tick(2);
    check("R6 off before ack sync", bus_off, 1'b1);
    tick(1);
    check("R6 bus returned", bus_off, 1'b0);
    check("R6 no grant", grant_n, 1'b1);
  endtask

  task automatic t_mid_cycle;
    cyc = 1'b1;
    req_n = 1'b0;
    tick(3);
    check("R2 grant during local cycle", grant_n, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check("R3 drivers on during RMW", bus_off, 1'b0);
    end
    cyc = 1'b0;
    tick(1);
    check("R3 release after cycle end", bus_off, 1'b1);
    req_n = 1'b1;
    tick(2);
    check("R4 grant before req sync", grant_n, 1'b0);
    tick(1);
    check("R4 grant withdrawn after release", grant_n, 1'b1);
    check("R4 drivers back on", bus_off, 1'b0);
  endtask

  task automatic t_withdraw_in_cycle;
    cyc = 1'b1;
    req_n = 1'b0;
    tick(3);
    check("R2 grant", grant_n, 1'b0);
    req_n = 1'b1;
    tick(3);
    check("R4 grant withdrawn mid cycle", grant_n, 1'b1);
    check("R4 drivers never off", bus_off, 1'b0);
    cyc = 1'b0;
    tick(2);
    check("R4 local keeps bus", bus_off, 1'b0);
  endtask

  task automatic t_regrant;
    req_n = 1'b0;
    tick(4);
    check("R3 released", bus_off, 1'b1);
    ack_n = 1'b0;
    tick(3);
    check("R5 ext owns", grant_n, 1'b1);
    ack_n = 1'b1;
    tick(1);
    check("R7 off edge 1", bus_off, 1'b1);
    tick(1);
    check("R7 no grant edge 2", grant_n, 1'b1);
    check("R7 off edge 2", bus_off, 1'b1);
    tick(1);
    check("R7 regranted", grant_n, 1'b0);
    check("R7 drivers still off", bus_off, 1'b1);
    ack_n = 1'b0;
    tick(3);
    req_n = 1'b1;
    ack_n = 1'b1;
    tick(4);
    check("R6 returned after regrant", bus_off, 1'b0);
  endtask

  task automatic t_two_wire;
    two_wire = 1'b1;
    tick(1);
    req_n = 1'b0;
    tick(4);
    check("R8 grant", grant_n, 1'b0);
    check("R8 released", bus_off, 1'b1);
    ack_n = 1'b0;
    tick(4);
    check("R8 ack ignored grant", grant_n, 1'b0);
    check("R8 ack ignored drivers", bus_off, 1'b1);
    ack_n = 1'b1;
    req_n = 1'b1;
    tick(2);
    check("R8 off before req sync", bus_off, 1'b1);
    tick(1);
    check("R8 returned", bus_off, 1'b0);
    check("R8 grant removed", grant_n, 1'b1);
    two_wire = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    t_three_wire_idle();
    t_mid_cycle();
    t_withdraw_in_cycle();
    t_regrant();
    t_two_wire();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule